// File: doc/BRIEF.md
# I2C Master End-of-Count Sequencer

This block sits between the software-visible control settings of an I2C master and its bit-level engine. It keeps a byte counter, loaded with the programmed count when a transfer starts, and lowers it by one on each byte-done strobe from the engine. When the counter runs out, it picks the action that follows. It can hold the bus and ask for a fresh count. It can send or check one extra packet-error-check byte. It can issue a STOP or a repeated start, or it can raise a transfer-complete flag and wait for software.

For a read transfer, the block also decides whether the engine should ACK or NACK the byte now being received. The final byte before a STOP or a repeated start, and the packet-error-check byte, are always NACKed, whatever the software NACK setting. Dropping the enable input returns the block to idle within one clock.

Top module: `i2cEndSeq`

## Requirements
- R1: After reset, and while idle, busStart, busStop, stallReq, tcFlag, pecPhase, busy and ackOut are 0 and remCount is 0.
- R2: In idle, a swStart pulse with a nonzero cfgCount pulses busStart for one cycle in the next cycle, sets busy and loads remCount with cfgCount. A swStart with cfgCount of 0 is ignored.
- R3: While a transfer runs, each byteDone lowers remCount by exactly one.
- R4: If cfgReload is 1 when the last counted byte completes, the block enters a hold state with stallReq at 1. It issues no STOP, no start and no check byte, whatever cfgAutoEnd, cfgPec or a pending start request say. A reloadLoad pulse with a nonzero cfgCount then loads remCount and resumes the transfer.
- R5: With cfgReload 0 and cfgAutoEnd 1, the end of the count pulses busStop for one cycle and the block returns to idle.
- R6: With cfgReload 0 and cfgAutoEnd 0, a start request that is pending at the end of the count (any swStart seen since the transfer began, including in that same cycle) pulses busStart instead of issuing a STOP. It also reloads remCount from cfgCount and clears the pending request.
- R7: With cfgReload 0, cfgAutoEnd 0 and no start pending, the end of the count raises tcFlag and holds it. A later swStart with a nonzero count issues a repeated start. A later swStop pulses busStop and returns to idle. If both arrive together, the start wins. swStop has no effect anywhere else.
- R8: With cfgPec 1 and cfgReload 0, one extra byte follows the last counted byte, with pecPhase at 1. The end action is taken when that byte completes.
- R9: ackOut is 1 only during a read (cfgRead 1), while a counted byte or the check byte is in progress, and only when swNack is 0. It is forced to 0 for the check byte, and for the last counted byte when cfgReload and cfgPec are both 0.
- R10: While enable is 0, the block goes to idle at the next clock edge, with remCount 0 and any pending start discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; 0 forces idle |
| swStart | input | 1 | Software start / repeated-start request pulse |
| swStop | input | 1 | Software stop request pulse (honoured while tcFlag is 1) |
| swNack | input | 1 | Software NACK preference for received bytes |
| cfgRead | input | 1 | Transfer direction, 1 = master receive |
| cfgReload | input | 1 | Hold the bus and request a new count at end of count |
| cfgAutoEnd | input | 1 | Issue STOP automatically at end of count |
| cfgPec | input | 1 | Append one packet-error-check byte |
| cfgCount | input | 8 | Byte count to load |
| byteDone | input | 1 | Engine strobe: one byte finished |
| reloadLoad | input | 1 | Pulse: load cfgCount while holding for reload |
| busStart | output | 1 | One-cycle request for a start or repeated start |
| busStop | output | 1 | One-cycle request for a STOP |
| stallReq | output | 1 | Holding the bus, waiting for a new count |
| tcFlag | output | 1 | Transfer complete, waiting for software |
| pecPhase | output | 1 | The check byte is in progress |
| busy | output | 1 | A transfer is active |
| ackOut | output | 1 | 1 = ACK the byte being received |
| remCount | output | 8 | Bytes remaining in the current count |

## Verification
Several rules are checked on every cycle. The forced NACK on the last counted byte and on the check byte must hold. Each byte must lower the count by exactly one, and a start must load the programmed count. No start or stop may be issued while holding for a reload. Disable must empty the block, and a STOP must leave it idle. The choice among reload hold, check byte, STOP, repeated start and the complete flag depends on settings and on swStart requests made earlier in the transfer. Only the bench scenarios can show that choice: reload with every other option set, a start requested mid-transfer or in the final cycle, complete-flag exits through start and through stop, and disable mid-transfer. A behavioural reference model is compared against every output on every clock.

// File: rtl/i2cEndPkg.sv
package i2cEndPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_PEC,
    ST_RELOAD,
    ST_TC
  } seqState_t;

  typedef struct packed {
    logic load;
    logic dec;
    logic clr;
  } cntCmd_t;
endpackage

// File: rtl/i2cEndCounter.sv
module i2cEndCounter
  import i2cEndPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             cntLast
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          count <= '0;
    else if (cmd.clr)                   count <= '0;
    else if (cmd.load)                  count <= loadVal;
    else if (cmd.dec && count != '0)    count <= count - ONE;
  end

  assign cntLast = (count == ONE);
endmodule

// File: rtl/i2cEndControl.sv
module i2cEndControl
  import i2cEndPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      swStart,
  input  logic      swStop,
  input  logic      byteDone,
  input  logic      reloadLoad,
  input  logic      cfgReload,
  input  logic      cfgAutoEnd,
  input  logic      cfgPec,
  input  logic      countNonZero,
  input  logic      cntLast,
  output cntCmd_t   cmd,
  output seqState_t state,
  output logic      busStart,
  output logic      busStop
);
  seqState_t nextState;
  logic startPend, pendNext, startNow, stopNow, doEnd;

  always_comb begin
    nextState = state;
    cmd       = '0;
    pendNext  = startPend;
    startNow  = 1'b0;
    stopNow   = 1'b0;
    doEnd     = 1'b0;
    if (!enable) begin
      nextState = ST_IDLE;
      cmd.clr   = 1'b1;
      pendNext  = 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (swStart && countNonZero) begin
            cmd.load  = 1'b1;
            startNow  = 1'b1;
            nextState = ST_XFER;
          end
        end
        ST_XFER: begin
          if (swStart) pendNext = 1'b1;
          if (byteDone) begin
            cmd.dec = 1'b1;
            if (cntLast) begin
              if (cfgReload)   nextState = ST_RELOAD;
              else if (cfgPec) nextState = ST_PEC;
              else             doEnd = 1'b1;
            end
          end
        end
        ST_PEC: begin
          if (swStart) pendNext = 1'b1;
          if (byteDone) doEnd = 1'b1;
        end
        ST_RELOAD: begin
          if (swStart) pendNext = 1'b1;
          if (reloadLoad && countNonZero) begin
            cmd.load  = 1'b1;
            nextState = ST_XFER;
          end
        end
        ST_TC: begin
          if (swStart && countNonZero) begin
            cmd.load  = 1'b1;
            startNow  = 1'b1;
            nextState = ST_XFER;
          end else if (swStop) begin
            stopNow   = 1'b1;
            cmd.clr   = 1'b1;
            nextState = ST_IDLE;
          end
        end
        default: nextState = ST_IDLE;
      endcase
      if (doEnd) begin
        if (cfgAutoEnd) begin
          stopNow   = 1'b1;
          nextState = ST_IDLE;
        end else if (pendNext && countNonZero) begin
          cmd.load  = 1'b1;
          startNow  = 1'b1;
          nextState = ST_XFER;
        end else begin
          nextState = ST_TC;
        end
      end
      if (startNow || stopNow) pendNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      startPend <= 1'b0;
      busStart  <= 1'b0;
      busStop   <= 1'b0;
    end else begin
      state     <= nextState;
      startPend <= pendNext;
      busStart  <= startNow;
      busStop   <= stopNow;
    end
  end
endmodule

// File: rtl/i2cEndSeq.sv
module i2cEndSeq
  import i2cEndPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             swStart,
  input  logic             swStop,
  input  logic             swNack,
  input  logic             cfgRead,
  input  logic             cfgReload,
  input  logic             cfgAutoEnd,
  input  logic             cfgPec,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             byteDone,
  input  logic             reloadLoad,
  output logic             busStart,
  output logic             busStop,
  output logic             stallReq,
  output logic             tcFlag,
  output logic             pecPhase,
  output logic             busy,
  output logic             ackOut,
  output logic [CNT_W-1:0] remCount
);
  cntCmd_t   cmd;
  seqState_t state;
  logic      cntLast, lastRx, rxByte;

  i2cEndCounter #(.CNT_W(CNT_W)) uCounter (
    .clk(clk), .rstN(rstN), .cmd(cmd), .loadVal(cfgCount),
    .count(remCount), .cntLast(cntLast)
  );

  i2cEndControl uControl (
    .clk(clk), .rstN(rstN), .enable(enable), .swStart(swStart),
    .swStop(swStop), .byteDone(byteDone), .reloadLoad(reloadLoad),
    .cfgReload(cfgReload), .cfgAutoEnd(cfgAutoEnd), .cfgPec(cfgPec),
    .countNonZero(cfgCount != '0), .cntLast(cntLast), .cmd(cmd),
    .state(state), .busStart(busStart), .busStop(busStop)
  );

  assign stallReq = (state == ST_RELOAD);
  assign tcFlag   = (state == ST_TC);
  assign pecPhase = (state == ST_PEC);
  assign busy     = (state != ST_IDLE);
  assign rxByte   = (state == ST_XFER) || (state == ST_PEC);
  assign lastRx   = (state == ST_PEC) ||
                    ((state == ST_XFER) && cntLast && !cfgReload && !cfgPec);
  assign ackOut   = cfgRead && rxByte && !lastRx && !swNack;
endmodule

// File: rtl/i2cEndSeqChk.sv
module i2cEndSeqChk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             cfgRead,
  input logic             cfgReload,
  input logic             cfgPec,
  input logic [CNT_W-1:0] cfgCount,
  input logic             byteDone,
  input logic             swStart,
  input logic             swStop,
  input logic             busStart,
  input logic             busStop,
  input logic             stallReq,
  input logic             tcFlag,
  input logic             pecPhase,
  input logic             busy,
  input logic             ackOut,
  input logic [CNT_W-1:0] remCount
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic inXfer;
  assign inXfer = busy && !stallReq && !tcFlag && !pecPhase;

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    busStart |-> (busy && remCount == $past(cfgCount)));  // R2
  AST_BYTE_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (enable && inXfer && byteDone && remCount > ONE) |=> (remCount == $past(remCount) - ONE));  // R3
  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |-> (!busStart && !busStop && !pecPhase));  // R4
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    busStop |-> (!busy && !busStart));  // R5
  AST_TC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && tcFlag && !swStart && !swStop) |=> tcFlag);  // R7
  AST_PEC_NACK: assert property (@(posedge clk) disable iff (!rstN)
    pecPhase |-> !ackOut);  // R9
  AST_LAST_NACK: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRead && inXfer && remCount == ONE && !cfgReload && !cfgPec) |-> !ackOut);  // R9
  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!busy && remCount == '0));  // R10
endmodule

bind i2cEndSeq i2cEndSeqChk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .cfgRead(cfgRead),
  .cfgReload(cfgReload), .cfgPec(cfgPec), .cfgCount(cfgCount),
  .byteDone(byteDone), .swStart(swStart), .swStop(swStop),
  .busStart(busStart), .busStop(busStop), .stallReq(stallReq),
  .tcFlag(tcFlag), .pecPhase(pecPhase), .busy(busy), .ackOut(ackOut),
  .remCount(remCount)
);

// File: tb/i2cEndSeq_test.sv
module i2cEndSeq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 0, rstN = 0, enable = 0;
  logic swStart = 0, swStop = 0, swNack = 0, cfgRead = 0;
  logic cfgReload = 0, cfgAutoEnd = 0, cfgPec = 0;
  logic [7:0] cfgCount = 0;
  logic byteDone = 0, reloadLoad = 0;
  logic busStart, busStop, stallReq, tcFlag, pecPhase, busy, ackOut;
  logic [7:0] remCount;

  int nCompared = 0, nFailed = 0, cycles = 0;
  int sawStop = 0, sawStart = 0, sawStall = 0, sawPec = 0, sawTc = 0;

  // reference model state: 0 idle, 1 xfer, 2 check byte, 3 reload hold, 4 complete
  int mSt = 0, mCnt = 0;
  bit mPend = 0, mStartP = 0, mStopP = 0;

  i2cEndSeq uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    bit endAct;
    if (!rstN) begin
      mSt = 0; mCnt = 0; mPend = 0; mStartP = 0; mStopP = 0;
    end else begin
      mStartP = 0; mStopP = 0; endAct = 0;
      if (!enable) begin
        mSt = 0; mCnt = 0; mPend = 0;
      end else begin
        case (mSt)
          0: if (swStart && cfgCount != 0) begin mCnt = cfgCount; mStartP = 1; mSt = 1; end
          1: begin
            if (swStart) mPend = 1;
            if (byteDone) begin
              mCnt = mCnt - 1;
              if (mCnt == 0) begin
                if (cfgReload) mSt = 3;
                else if (cfgPec) mSt = 2;
                else endAct = 1;
              end
            end
          end
          2: begin if (swStart) mPend = 1; if (byteDone) endAct = 1; end
          3: begin
            if (swStart) mPend = 1;
            if (reloadLoad && cfgCount != 0) begin mCnt = cfgCount; mSt = 1; end
          end
          default: begin
            if (swStart && cfgCount != 0) begin mCnt = cfgCount; mStartP = 1; mSt = 1; mPend = 0; end
            else if (swStop) begin mStopP = 1; mSt = 0; mPend = 0; end
          end
        endcase
        if (endAct) begin
          if (cfgAutoEnd) begin mStopP = 1; mSt = 0; mPend = 0; end
          else if (mPend && cfgCount != 0) begin mCnt = cfgCount; mStartP = 1; mSt = 1; mPend = 0; end
          else mSt = 4;
        end
      end
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    nCompared++;
    if (act != exp) begin
      nFailed++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit mAck, mLast;
    cycles++;
    if (rstN) begin
      mLast = (mSt == 2) || (mSt == 1 && mCnt == 1 && !cfgReload && !cfgPec);
      mAck  = cfgRead && (mSt == 1 || mSt == 2) && !mLast && !swNack;
      cmp("R1 busy", busy, mSt != 0);
      cmp("R2/R6/R7 busStart", busStart, mStartP);
      cmp("R5/R7 busStop", busStop, mStopP);
      cmp("R3 remCount", remCount, mCnt);
      cmp("R4 stallReq", stallReq, mSt == 3);
      cmp("R7 tcFlag", tcFlag, mSt == 4);
      cmp("R8 pecPhase", pecPhase, mSt == 2);
      cmp("R9 ackOut", ackOut, mAck);
      sawStop += busStop; sawStart += busStart; sawStall += stallReq;
      sawPec += pecPhase; sawTc += tcFlag;
    end
    if (cycles > WATCHDOG) begin
      nFailed++;
      $display("FAIL watchdog expired: actual %0d expected <= %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic doStart(input int cnt);
    cfgCount = 8'(cnt); swStart = 1; step(); swStart = 0;
  endtask

  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) begin byteDone = 1; step(); byteDone = 0; step(); end
  endtask

  task automatic expectSeen(input string tag, input int seen);
    nCompared++;
    if (seen == 0) begin
      nFailed++;
      $display("FAIL %s: actual 0 expected nonzero", tag);
    end
  endtask

  initial begin
    step(2);
    // R1: reset state
    cmp("R1 reset busy", busy, 0);
    cmp("R1 reset remCount", remCount, 0);
    rstN = 1; enable = 1; step(2);

    // R2: zero count ignored
    doStart(0); step(2);
    cmp("R2 zero count ignored", busy, 0);

    // R5: write, auto end
    cfgAutoEnd = 1; doStart(3); step(); bytes(3); step(2);
    expectSeen("R5 stop issued", sawStop);

    // R7/R9: read, complete flag then stop; R3 back-to-back bytes
    cfgAutoEnd = 0; cfgRead = 1; doStart(4);
    byteDone = 1; step(2); byteDone = 0; step(); bytes(2); step(3);
    expectSeen("R7 complete flag", sawTc);
    swStop = 1; step(); swStop = 0; step(2);
    cmp("R7 stop leaves idle", busy, 0);

    // R7: complete flag exited by start
    doStart(2); bytes(2); step(2);
    doStart(1); bytes(1); swStop = 1; step(); swStop = 0; step(2);

    // R6: start pending mid transfer, and in the final cycle
    doStart(3); byteDone = 1; step(); byteDone = 0;
    swStart = 1; step(); swStart = 0; cfgCount = 2; bytes(2); step();
    bytes(1); swStart = 1; byteDone = 1; step(); swStart = 0; byteDone = 0; step(3);
    cfgAutoEnd = 1; bytes(2); step(2);
    cmp("R6 sequence ends idle", busy, 0);

    // R4: reload with every other option set
    cfgReload = 1; cfgPec = 1; cfgAutoEnd = 1; swNack = 0;
    doStart(2); bytes(1); swStart = 1; step(); swStart = 0; bytes(1); step(3);
    expectSeen("R4 stall seen", sawStall);
    swStop = 1; step(); swStop = 0; step();
    cmp("R4/R7 stop ignored while holding", stallReq, 1);
    cfgReload = 0; cfgPec = 0; cfgCount = 2; reloadLoad = 1; step(); reloadLoad = 0;
    cmp("R4 reload count", remCount, 2);
    bytes(2); step(2);

    // R8/R9: check byte in read with ack preference set to ACK
    cfgPec = 1; cfgAutoEnd = 1; doStart(2); bytes(2); step(); bytes(1); step(2);
    expectSeen("R8 check byte phase", sawPec);

    // R9: software NACK on every byte
    swNack = 1; cfgPec = 0; doStart(3); bytes(3); step(2); swNack = 0;

    // R10: disable mid transfer
    cfgRead = 0; doStart(5); bytes(2); enable = 0; step(2);
    cmp("R10 disabled idle", busy, 0);
    cmp("R10 disabled count", remCount, 0);
    enable = 1; step(3);
    expectSeen("R2 start pulses", sawStart);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
    $finish;
  end
endmodule